// File: doc/BRIEF.md
# Composite Video Timing Generator

This block produces the raster timing for an interlaced composite video encoder running as the timing source. A 27 MHz clock with a 13.5 MHz sample enable drives a pixel counter and a line counter. The block decodes these counters into active-low horizontal sync and vertical sync, a window marking active picture samples, and a gate marking where the colour burst belongs. It also keeps a field-sequence index, which the subcarrier stage uses to alternate burst phase.

Two select pins choose one of four standards: a 525-line system without phase alternation, a 525-line phase-alternating system, a 625-line phase-alternating system, and a 625-line phase-alternating variant with a wider burst. In the alternative mode the vertical sync pin carries which field is in progress instead of a sync pulse. The horizontal geometry is set by parameters whose defaults are the broadcast sample counts. The line ranges are fixed by each standard.

Top module: `video_timing_gen`

## Requirements
- R1: `pixelCount` starts at 1 and increases by one on every cycle with `sampleEn` high. After the line total it returns to 1. The line total is front porch + back porch + active: 20+127+711 = 858 for 525-line standards and 20+142+702 = 864 for 625-line standards.
- R2: `lineCount` increases by one when `pixelCount` wraps. After 525 lines (525-line standards) or 625 lines (625-line standards) it returns to 1.
- R3: While `sampleEn` is low, the counters, the field index, `hsyncN`, `active` and `burstGate` keep their values.
- R4: The standard is {`pal625`,`palsa`}: 00 is 525-line non-alternating, 01 is 525-line alternating, 10 is 625-line alternating, and 11 is the 625-line wide-burst variant. The pins are taken while `rst` is high and again only on the sample where `lineCount` wraps to 1. A change at any other time has no effect until then.
- R5: `hsyncN` is low for pixels 1 to 64 on 525-line standards and for pixels 1 to 63 on 625-line standards. It is high for all other pixels.
- R6: With `efield` low, `vsyncN` is low for three lines from each field start and high otherwise. The first field starts at line 1. The second field starts at line 263 (525-line) or line 313 (625-line).
- R7: With `efield` high, `vsyncN` is low for every line of the first field and high for every line of the second field.
- R8: `active` is high when two conditions hold. The pixel must lie after the back porch and within the active span: 128–838 (525-line) or 143–844 (625-line). The line must not be one of these: lines 1–22, 263–284 and 524 for 525-line; lines 1–22, 311–335 and 623–625 for 625-line.
- R9: Outside the suppressed lines, `burstGate` is high for pixels start to start+width−1. Start/width is 72/34 (00), 78/34 (01), 76/30 (10) and 76/34 (11). The burst lies after sync and before active picture.
- R10: On the 525-line non-alternating standard, burst is suppressed on lines 1–9 and 264–272.
- R11: On the 525-line alternating standard, burst is suppressed on lines 1–11 and 264–273 in fields 1, 2, 5 and 6. It is suppressed on lines 1–10 and 264–272 in fields 3, 4, 7 and 8.
- R12: On both 625-line standards, burst is suppressed on lines 1–6, 310–318 and 623–625 in fields 1, 2, 5 and 6. It is suppressed on lines 1–5, 311–319 and 622–625 in fields 3, 4, 7 and 8.
- R13: `fieldIndex` steps by one at each field start. It wraps 4→1 on the non-alternating standard and 8→1 on the other three. It restarts at 1 when a new standard takes effect, so odd values are always first fields.
- R14: After reset, `pixelCount` = 1, `lineCount` = 1 and `fieldIndex` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz clock |
| rst | input | 1 | Synchronous reset, active high; also loads the standard |
| sampleEn | input | 1 | Sample enable, high on every 13.5 MHz sample |
| pal625 | input | 1 | Standard select, upper bit (625-line) |
| palsa | input | 1 | Standard select, lower bit (alternate variant) |
| efield | input | 1 | 1: vsyncN carries field identity |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low, or field identity |
| active | output | 1 | Active picture sample |
| burstGate | output | 1 | Colour burst window |
| pixelCount | output | PixW | Sample position in line, from 1 |
| lineCount | output | 10 | Line in frame, from 1 |
| fieldIndex | output | 4 | Field in the burst-phase sequence, from 1 |

## Verification
The bench shrinks the horizontal geometry to lines of 16 samples (525-line) and 18 samples (625-line). Sync, burst and active-picture segments are scaled but keep their order. The vertical line ranges are not parameters, so they keep their real values. With short lines, several full frames of every standard fit in a short run. That brings within reach the burst suppression ranges of both field groups, the wrap of the eight-field sequence, and standard changes requested mid-frame that take effect at the next frame start.

// File: rtl/vtg_pkg.sv
`timescale 1ns/1ps
package vtg_pkg;

  localparam int LINE_W      = 10;
  localparam int FIELD_W     = 4;
  localparam int LINES_525   = 525;
  localparam int LINES_625   = 625;
  localparam int FIELD2_525  = 263;
  localparam int FIELD2_625  = 313;
  localparam int VSYNC_LINES = 3;

  // {pal625, palsa}
  typedef enum logic [1:0] {
    STD_NTSC  = 2'b00,
    STD_PALM  = 2'b01,
    STD_PALBG = 2'b10,
    STD_PALNC = 2'b11
  } vidStd_t;

  // Per-sample strobes from control to the counter datapath
  typedef struct packed {
    logic step;
    logic lineWrap;
    logic frameWrap;
    logic field2Start;
  } vtgStrobe_t;

endpackage

// File: rtl/vtg_control.sv
`timescale 1ns/1ps
module vtg_control
  import vtg_pkg::*;
#(
  parameter int PIXW             = 10,
  parameter int H_FRONT_525      = 20,
  parameter int H_BACK_525       = 127,
  parameter int H_ACTIVE_525     = 711,
  parameter int H_FRONT_625      = 20,
  parameter int H_BACK_625       = 142,
  parameter int H_ACTIVE_625     = 702,
  parameter int HSYNC_525        = 64,
  parameter int HSYNC_625        = 63,
  parameter int BURST_START_NTSC = 72,
  parameter int BURST_WIDTH_NTSC = 34,
  parameter int BURST_START_PALM = 78,
  parameter int BURST_WIDTH_PALM = 34,
  parameter int BURST_START_BG   = 76,
  parameter int BURST_WIDTH_BG   = 30,
  parameter int BURST_START_NC   = 76,
  parameter int BURST_WIDTH_NC   = 34
) (
  input  logic               sampleEn,
  input  logic               efield,
  input  logic [PIXW-1:0]    pixelCount,
  input  logic [LINE_W-1:0]  lineCount,
  input  logic [FIELD_W-1:0] fieldIndex,
  input  vidStd_t            stdCur,
  output vtgStrobe_t         strobe,
  output logic               hsyncN,
  output logic               vsyncN,
  output logic               active,
  output logic               burstGate
);

  localparam int HTOT_525 = H_FRONT_525 + H_BACK_525 + H_ACTIVE_525;
  localparam int HTOT_625 = H_FRONT_625 + H_BACK_625 + H_ACTIVE_625;

  function automatic logic between(int v, int lo, int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  logic is525, groupB, firstField, vsWin, lineActive, burstOff;
  int   pixI, lineI, pixTot, lineTot, f2Line, hsw, backP, actW, bStart, bWidth;

  always_comb begin
    is525   = !stdCur[1];
    pixI    = int'(pixelCount);
    lineI   = int'(lineCount);
    pixTot  = is525 ? HTOT_525   : HTOT_625;
    lineTot = is525 ? LINES_525  : LINES_625;
    f2Line  = is525 ? FIELD2_525 : FIELD2_625;
    hsw     = is525 ? HSYNC_525  : HSYNC_625;
    backP   = is525 ? H_BACK_525 : H_BACK_625;
    actW    = is525 ? H_ACTIVE_525 : H_ACTIVE_625;
    groupB  = (fieldIndex == FIELD_W'(3)) || (fieldIndex == FIELD_W'(4)) ||
              (fieldIndex == FIELD_W'(7)) || (fieldIndex == FIELD_W'(8));

    unique case (stdCur)
      STD_NTSC: begin
        bStart   = BURST_START_NTSC; bWidth = BURST_WIDTH_NTSC;
        burstOff = between(lineI, 1, 9) || between(lineI, 264, 272);
      end
      STD_PALM: begin
        bStart   = BURST_START_PALM; bWidth = BURST_WIDTH_PALM;
        burstOff = groupB ? (between(lineI, 1, 10) || between(lineI, 264, 272))
                          : (between(lineI, 1, 11) || between(lineI, 264, 273));
      end
      STD_PALBG: begin
        bStart   = BURST_START_BG; bWidth = BURST_WIDTH_BG;
        burstOff = groupB ? (between(lineI, 1, 5) || between(lineI, 311, 319) ||
                             between(lineI, 622, 625))
                          : (between(lineI, 1, 6) || between(lineI, 310, 318) ||
                             between(lineI, 623, 625));
      end
      default: begin
        bStart   = BURST_START_NC; bWidth = BURST_WIDTH_NC;
        burstOff = groupB ? (between(lineI, 1, 5) || between(lineI, 311, 319) ||
                             between(lineI, 622, 625))
                          : (between(lineI, 1, 6) || between(lineI, 310, 318) ||
                             between(lineI, 623, 625));
      end
    endcase

    // sequencing strobes
    strobe.step        = sampleEn;
    strobe.lineWrap    = sampleEn && (pixI == pixTot);
    strobe.frameWrap   = strobe.lineWrap && (lineI == lineTot);
    strobe.field2Start = strobe.lineWrap && (lineI == f2Line - 1);

    // vertical decode
    firstField = lineI < f2Line;
    vsWin      = between(lineI, 1, VSYNC_LINES) ||
                 between(lineI, f2Line, f2Line + VSYNC_LINES - 1);
    if (is525)
      lineActive = !(between(lineI, 1, 22) || between(lineI, 263, 284) || lineI == 524);
    else
      lineActive = !(between(lineI, 1, 22) || between(lineI, 311, 335) ||
                     between(lineI, 623, 625));

    // waveform outputs
    hsyncN    = !between(pixI, 1, hsw);
    vsyncN    = efield ? !firstField : !vsWin;
    active    = lineActive && between(pixI, backP + 1, backP + actW);
    burstGate = !burstOff && between(pixI, bStart, bStart + bWidth - 1);
  end

endmodule

// File: rtl/vtg_counters.sv
`timescale 1ns/1ps
module vtg_counters
  import vtg_pkg::*;
#(
  parameter int PIXW = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pal625,
  input  logic               palsa,
  input  vtgStrobe_t         strobe,
  output logic [PIXW-1:0]    pixelCount,
  output logic [LINE_W-1:0]  lineCount,
  output logic [FIELD_W-1:0] fieldIndex,
  output vidStd_t            stdCur
);

  vidStd_t            pinStd;
  logic [FIELD_W-1:0] fieldMax;
  logic [FIELD_W-1:0] fieldNext;

  always_comb begin
    pinStd    = vidStd_t'({pal625, palsa});
    fieldMax  = (stdCur == STD_NTSC) ? FIELD_W'(4) : FIELD_W'(8);
    fieldNext = (fieldIndex == fieldMax) ? FIELD_W'(1) : fieldIndex + FIELD_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pixelCount <= PIXW'(1);
      lineCount  <= LINE_W'(1);
      fieldIndex <= FIELD_W'(1);
      stdCur     <= pinStd;
    end else if (strobe.step) begin
      if (strobe.lineWrap) begin
        pixelCount <= PIXW'(1);
        if (strobe.frameWrap) begin
          lineCount  <= LINE_W'(1);
          stdCur     <= pinStd;
          fieldIndex <= (pinStd != stdCur) ? FIELD_W'(1) : fieldNext;
        end else begin
          lineCount <= lineCount + LINE_W'(1);
          if (strobe.field2Start) fieldIndex <= fieldNext;
        end
      end else begin
        pixelCount <= pixelCount + PIXW'(1);
      end
    end
  end

endmodule

// File: rtl/video_timing_gen.sv
`timescale 1ns/1ps
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int H_FRONT_525      = 20,
  parameter int H_BACK_525       = 127,
  parameter int H_ACTIVE_525     = 711,
  parameter int H_FRONT_625      = 20,
  parameter int H_BACK_625       = 142,
  parameter int H_ACTIVE_625     = 702,
  parameter int HSYNC_525        = 64,
  parameter int HSYNC_625        = 63,
  parameter int BURST_START_NTSC = 72,
  parameter int BURST_WIDTH_NTSC = 34,
  parameter int BURST_START_PALM = 78,
  parameter int BURST_WIDTH_PALM = 34,
  parameter int BURST_START_BG   = 76,
  parameter int BURST_WIDTH_BG   = 30,
  parameter int BURST_START_NC   = 76,
  parameter int BURST_WIDTH_NC   = 34,
  localparam int HTOT_MAX = ((H_FRONT_525 + H_BACK_525 + H_ACTIVE_525) >
                             (H_FRONT_625 + H_BACK_625 + H_ACTIVE_625)) ?
                            (H_FRONT_525 + H_BACK_525 + H_ACTIVE_525) :
                            (H_FRONT_625 + H_BACK_625 + H_ACTIVE_625),
  localparam int PixW = $clog2(HTOT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sampleEn,
  input  logic               pal625,
  input  logic               palsa,
  input  logic               efield,
  output logic               hsyncN,
  output logic               vsyncN,
  output logic               active,
  output logic               burstGate,
  output logic [PixW-1:0]    pixelCount,
  output logic [LINE_W-1:0]  lineCount,
  output logic [FIELD_W-1:0] fieldIndex
);

  vtgStrobe_t strobe;
  vidStd_t    stdCur;

  vtg_control #(
    .PIXW(PixW),
    .H_FRONT_525(H_FRONT_525), .H_BACK_525(H_BACK_525), .H_ACTIVE_525(H_ACTIVE_525),
    .H_FRONT_625(H_FRONT_625), .H_BACK_625(H_BACK_625), .H_ACTIVE_625(H_ACTIVE_625),
    .HSYNC_525(HSYNC_525), .HSYNC_625(HSYNC_625),
    .BURST_START_NTSC(BURST_START_NTSC), .BURST_WIDTH_NTSC(BURST_WIDTH_NTSC),
    .BURST_START_PALM(BURST_START_PALM), .BURST_WIDTH_PALM(BURST_WIDTH_PALM),
    .BURST_START_BG(BURST_START_BG), .BURST_WIDTH_BG(BURST_WIDTH_BG),
    .BURST_START_NC(BURST_START_NC), .BURST_WIDTH_NC(BURST_WIDTH_NC)
  ) uCtrl (
    .sampleEn(sampleEn), .efield(efield),
    .pixelCount(pixelCount), .lineCount(lineCount), .fieldIndex(fieldIndex),
    .stdCur(stdCur), .strobe(strobe),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .active(active), .burstGate(burstGate)
  );

  vtg_counters #(.PIXW(PixW)) uCnt (
    .clk(clk), .rst(rst), .pal625(pal625), .palsa(palsa), .strobe(strobe),
    .pixelCount(pixelCount), .lineCount(lineCount), .fieldIndex(fieldIndex),
    .stdCur(stdCur)
  );

endmodule

// File: rtl/vtg_checker.sv
`timescale 1ns/1ps
module vtg_checker
  import vtg_pkg::*;
#(
  parameter int PIXW   = 10,
  parameter int HTOT5  = 858,
  parameter int HTOT6  = 864,
  parameter int HSW5   = 64,
  parameter int HSW6   = 63
) (
  input logic               clk,
  input logic               rst,
  input logic               sampleEn,
  input logic               efield,
  input logic [PIXW-1:0]    pixelCount,
  input logic [LINE_W-1:0]  lineCount,
  input logic [FIELD_W-1:0] fieldIndex,
  input logic               hsyncN,
  input logic               vsyncN,
  input logic               active,
  input logic               burstGate,
  input vidStd_t            stdCur
);

  logic is525, atLineEnd, atFrameEnd;
  int   hswCur, fieldTop;

  always_comb begin
    is525      = !stdCur[1];
    atLineEnd  = int'(pixelCount) == (is525 ? HTOT5 : HTOT6);
    atFrameEnd = int'(lineCount) == (is525 ? LINES_525 : LINES_625);
    hswCur     = is525 ? HSW5 : HSW6;
    fieldTop   = (stdCur == STD_NTSC) ? 4 : 8;
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !sampleEn |=> $stable(pixelCount) && $stable(lineCount) && $stable(fieldIndex) &&
                  $stable(hsyncN) && $stable(active) && $stable(burstGate));

  assert_pixel_step_R1: assert property (@(posedge clk) disable iff (rst)
    sampleEn && !atLineEnd |=> pixelCount == $past(pixelCount) + PIXW'(1));

  assert_pixel_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    sampleEn && atLineEnd |=> pixelCount == PIXW'(1));

  assert_line_step_R2: assert property (@(posedge clk) disable iff (rst)
    sampleEn && atLineEnd && !atFrameEnd |=> lineCount == $past(lineCount) + LINE_W'(1));

  assert_std_latch_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(stdCur) |-> pixelCount == PIXW'(1) && lineCount == LINE_W'(1));

  assert_hsync_span_R5: assert property (@(posedge clk) disable iff (rst)
    !hsyncN |-> int'(pixelCount) <= hswCur);

  assert_field_id_R7: assert property (@(posedge clk) disable iff (rst)
    efield && fieldIndex[0] |-> !vsyncN);

  assert_active_clear_R8: assert property (@(posedge clk) disable iff (rst)
    active |-> hsyncN);

  assert_burst_place_R9: assert property (@(posedge clk) disable iff (rst)
    burstGate |-> hsyncN && !active);

  assert_field_range_R13: assert property (@(posedge clk) disable iff (rst)
    fieldIndex != '0 && int'(fieldIndex) <= fieldTop);

endmodule

bind video_timing_gen vtg_checker #(
  .PIXW(PixW),
  .HTOT5(H_FRONT_525 + H_BACK_525 + H_ACTIVE_525),
  .HTOT6(H_FRONT_625 + H_BACK_625 + H_ACTIVE_625),
  .HSW5(HSYNC_525), .HSW6(HSYNC_625)
) uChk (
  .clk(clk), .rst(rst), .sampleEn(sampleEn), .efield(efield),
  .pixelCount(pixelCount), .lineCount(lineCount), .fieldIndex(fieldIndex),
  .hsyncN(hsyncN), .vsyncN(vsyncN), .active(active), .burstGate(burstGate),
  .stdCur(stdCur)
);

// File: tb/video_timing_gen_test.sv
`timescale 1ns/1ps
module video_timing_gen_test;

  // shortened horizontal geometry
  localparam int FP5 = 2, BP5 = 7, AC5 = 7, FP6 = 2, BP6 = 8, AC6 = 8;
  localparam int HS5 = 3, HS6 = 4;
  localparam int BSN = 4, BWN = 2, BSM = 5, BWM = 2, BSB = 5, BWB = 1, BSC = 5, BWC = 3;
  localparam int T5 = FP5 + BP5 + AC5, T6 = FP6 + BP6 + AC6;
  localparam int PIXW = $clog2(((T5 > T6) ? T5 : T6) + 1);

  logic clk = 1'b0, rst = 1'b1, sampleEn = 1'b0, pal625 = 1'b0, palsa = 1'b0, efield = 1'b0;
  logic hsyncN, vsyncN, active, burstGate;
  logic [PIXW-1:0] pixelCount;
  logic [9:0] lineCount;
  logic [3:0] fieldIndex;

  always #2 clk = ~clk;

  video_timing_gen #(
    .H_FRONT_525(FP5), .H_BACK_525(BP5), .H_ACTIVE_525(AC5),
    .H_FRONT_625(FP6), .H_BACK_625(BP6), .H_ACTIVE_625(AC6),
    .HSYNC_525(HS5), .HSYNC_625(HS6),
    .BURST_START_NTSC(BSN), .BURST_WIDTH_NTSC(BWN),
    .BURST_START_PALM(BSM), .BURST_WIDTH_PALM(BWM),
    .BURST_START_BG(BSB), .BURST_WIDTH_BG(BWB),
    .BURST_START_NC(BSC), .BURST_WIDTH_NC(BWC)
  ) uut (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .pal625(pal625), .palsa(palsa),
    .efield(efield), .hsyncN(hsyncN), .vsyncN(vsyncN), .active(active),
    .burstGate(burstGate), .pixelCount(pixelCount), .lineCount(lineCount),
    .fieldIndex(fieldIndex)
  );

  typedef struct {
    int pix; int line; int field;
    int hs; int vs; int act; int bg;
    string tagPix; string tagVs; string tagBg;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int mPix, mLine, mField, mStd;

  function automatic bit inR(int v, int lo, int hi);
    return v >= lo && v <= hi;
  endfunction

  function automatic int totPix(int s);  return (s < 2) ? T5 : T6;   endfunction
  function automatic int totLine(int s); return (s < 2) ? 525 : 625; endfunction
  function automatic int f2Of(int s);    return (s < 2) ? 263 : 313; endfunction
  function automatic int fMax(int s);    return (s == 0) ? 4 : 8;    endfunction

  task automatic chk(int actv, int expv, string tag);
    checks++;
    if (actv != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (line %0d pixel %0d)",
               tag, actv, expv, lineCount, pixelCount);
    end
  endtask

  task automatic modelStep(bit en, int pinStd);
    if (!en) return;
    if (mPix == totPix(mStd)) begin
      mPix = 1;
      if (mLine == totLine(mStd)) begin
        mLine = 1;
        mField = (pinStd != mStd || mField == fMax(mStd)) ? 1 : mField + 1;
        mStd = pinStd;
      end else begin
        mLine++;
        if (mLine == f2Of(mStd)) mField = (mField == fMax(mStd)) ? 1 : mField + 1;
      end
    end else mPix++;
  endtask

  function automatic exp_t expect_now(bit ef, bit en, int pinStd);
    exp_t e;
    bit grpB, sup, first, vsw;
    int hsw, bp, ac, bs, bw;
    bit is5 = mStd < 2;
    e.pix = mPix; e.line = mLine; e.field = mField;
    hsw = is5 ? HS5 : HS6; bp = is5 ? BP5 : BP6; ac = is5 ? AC5 : AC6;
    grpB = (mField == 3 || mField == 4 || mField == 7 || mField == 8);
    case (mStd)
      0: begin bs = BSN; bw = BWN; sup = inR(mLine,1,9) || inR(mLine,264,272); end
      1: begin bs = BSM; bw = BWM;
         sup = grpB ? (inR(mLine,1,10) || inR(mLine,264,272))
                    : (inR(mLine,1,11) || inR(mLine,264,273)); end
      default: begin
         bs = (mStd == 2) ? BSB : BSC; bw = (mStd == 2) ? BWB : BWC;
         sup = grpB ? (inR(mLine,1,5) || inR(mLine,311,319) || inR(mLine,622,625))
                    : (inR(mLine,1,6) || inR(mLine,310,318) || inR(mLine,623,625)); end
    endcase
    first = mLine < f2Of(mStd);
    vsw = inR(mLine, 1, 3) || inR(mLine, f2Of(mStd), f2Of(mStd) + 2);
    e.hs = inR(mPix, 1, hsw) ? 0 : 1;
    e.vs = ef ? (first ? 0 : 1) : (vsw ? 0 : 1);
    e.act = (inR(mPix, bp + 1, bp + ac) &&
             (is5 ? !(inR(mLine,1,22) || inR(mLine,263,284) || mLine == 524)
                  : !(inR(mLine,1,22) || inR(mLine,311,335) || inR(mLine,623,625)))) ? 1 : 0;
    e.bg = (!sup && inR(mPix, bs, bs + bw - 1)) ? 1 : 0;
    e.tagPix = !en ? "R3 hold" : (mStd != pinStd ? "R4 pending standard" : "R1 pixel");
    e.tagVs  = ef ? "R7 field identity" : "R6 vsync";
    e.tagBg  = !sup ? "R9 burst window" :
               (mStd == 0 ? "R10 burst suppress" : (mStd == 1 ? "R11 burst suppress" :
                "R12 burst suppress"));
    return e;
  endfunction

  // driver: one expected item per sample edge
  task automatic runFor(int n, bit p625, bit psa, bit ef, int gateMod);
    for (int i = 0; i < n; i++) begin
      bit en;
      @(negedge clk);
      en = (gateMod != 0 && i < 300) ? (i % gateMod != 0) : 1'b1;
      pal625 = p625; palsa = psa; efield = ef; sampleEn = en;
      modelStep(en, {30'd0, p625, psa});
      q.push_back(expect_now(ef, en, {30'd0, p625, psa}));
    end
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(int'(pixelCount), e.pix, e.tagPix);
        chk(int'(lineCount), e.line, "R2 line");
        chk(int'(fieldIndex), e.field, "R13 field index");
        chk(int'(hsyncN), e.hs, "R5 hsync");
        chk(int'(vsyncN), e.vs, e.tagVs);
        chk(int'(active), e.act, "R8 active");
        chk(int'(burstGate), e.bg, e.tagBg);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14 reset state
    chk(int'(pixelCount), 1, "R14 reset pixel");
    chk(int'(lineCount), 1, "R14 reset line");
    chk(int'(fieldIndex), 1, "R14 reset field");
    chk(int'(hsyncN), 0, "R14 reset hsync");
    chk(int'(vsyncN), 0, "R14 reset vsync");
    chk(int'(active) + int'(burstGate), 0, "R14 reset active/burst");
    mPix = 1; mLine = 1; mField = 1; mStd = 0;
    rst = 1'b0;
    runFor(17000, 1'b0, 1'b0, 1'b0, 3);      // 525 non-alternating, gated start (R3)
    runFor(25400, 1'b0, 1'b1, 1'b1, 0);      // 525 alternating, field identity
    runFor(53900, 1'b1, 1'b0, 1'b0, 4);      // 625, full eight-field wrap
    runFor(34250, 1'b1, 1'b1, 1'b1, 0);      // 625 wide burst
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 195000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule